// File: doc/BRIEF.md
# Repetition Bundle Encoder and Three-Way Classifier

This block serves both ends of a size-N repetition code. On the sending side, a purely combinational encoder copies one logical bit onto every wire of an N-wire bundle. On the receiving side, a pipelined decoder counts the wires that carry 1 in each received bundle. It then places the bundle in one of three classes: logical 0, logical 1, or erroneous. A programmable fraction Δ sets the two decision thresholds, and a band of counts between them is reported as erroneous instead of being forced to a value.

Error-rate experiments use the decoder with an expected-bit input that travels alongside each bundle. The block flags each result that disagrees with that expectation. Four saturating tallies record how many bundles were classified as 0, as 1 and as erroneous, and how many mismatched. A single synchronous clear zeroes all four tallies.

Δ is supplied as an unsigned fraction d / 2^FRAC_W. It is intended to lie strictly between 0 and 1/2, so d runs from 1 to 2^(FRAC_W-1) - 1. Both thresholds are evaluated exactly in integer arithmetic, so no rounding is involved. The reset input is expected to be released synchronously to `clk`.

Top module: `rep_bundle_codec`

## Requirements
- R1: `enc_bundle_o` equals `enc_bit_i` copied onto all BUNDLE_N wires, with no clock delay.
- R2: With r equal to the number of 1 wires in the sampled bundle and d equal to the sampled `dec_delta_i`, a bundle with r·2^FRAC_W > BUNDLE_N·(2^FRAC_W − d) is classified as logical 1. This is the condition r > N(1−Δ), and it is reported as `cls_code_o` = 2'b01.
- R3: A bundle with r·2^FRAC_W < BUNDLE_N·d is classified as logical 0. This is the condition r < NΔ, and it is reported as `cls_code_o` = 2'b00.
- R4: A bundle that meets neither strict condition, including counts exactly on a threshold, is classified as erroneous and reported as `cls_code_o` = 2'b10. The code 2'b11 never appears.
- R5: `dec_delta_i` and `dec_expect_i` are captured on the same edge as the bundle. Changing them after that edge has no effect on that bundle's result.
- R6: A bundle sampled with `dec_valid_i` high at edge k produces a one-cycle `cls_valid_o` pulse after edge k+L, where L = ceil(log2 BUNDLE_N)+1 (5 for the default of 16). A new bundle is accepted on every cycle.
- R7: `cls_mismatch_o` is 1 exactly when the result is erroneous, or when the decoded bit (bit 0 of the code) differs from the expected bit.
- R8: Each tally increments by one for each matching result, and the new value is visible one cycle after `cls_valid_o`. A tally holds at 2^CNT_W − 1 and never wraps.
- R9: `cnt_clear_i` zeroes all four tallies at the next edge. The clear takes priority over an increment in the same cycle.
- R10: During and after reset, `cls_valid_o` is 0 and all tallies read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_bit_i | input | 1 | Logical bit to encode |
| enc_bundle_o | output | BUNDLE_N | Encoded bundle |
| dec_valid_i | input | 1 | Received bundle present this cycle |
| dec_bundle_i | input | BUNDLE_N | Received bundle |
| dec_delta_i | input | FRAC_W | Fiducial fraction d, where Δ = d/2^FRAC_W |
| dec_expect_i | input | 1 | Bit the bundle is expected to carry |
| cnt_clear_i | input | 1 | Synchronous clear of all tallies |
| cls_valid_o | output | 1 | Classification result valid |
| cls_code_o | output | 2 | 00 logical 0, 01 logical 1, 10 erroneous |
| cls_mismatch_o | output | 1 | Result is erroneous or differs from the expected bit |
| cnt_zero_o | output | CNT_W | Tally of logical-0 results |
| cnt_one_o | output | CNT_W | Tally of logical-1 results |
| cnt_err_o | output | CNT_W | Tally of erroneous results |
| cnt_miss_o | output | CNT_W | Tally of mismatching results |

## Verification
Two functions can fall in the same cycle: a tally increment, driven by a result leaving the pipeline, and a synchronous clear. The bench provokes this collision by raising `cnt_clear_i` exactly while `cls_valid_o` is high for a mismatching bundle. The tallies must then read zero, not one, on the following cycle. A second collision occurs when a tally already at its ceiling receives another increment. A burst of back-to-back bundles at a narrow tally width drives the logical-1 tally past its maximum, and the bench expects it to hold there rather than wrap.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_ONE  = 2'b01,
    CLS_ERR  = 2'b10
  } cls_e;

  localparam int TALLY_NUM  = 4;
  localparam int TALLY_ZERO = 0;
  localparam int TALLY_ONE  = 1;
  localparam int TALLY_ERR  = 2;
  localparam int TALLY_MISS = 3;

endpackage

// File: rtl/rbc_popcount.sv
// Pipelined population count. Level 0 registers the bits, and each later
// level adds pairs from the previous one. Sideband data travels in step.
module rbc_popcount #(
  parameter int N      = 16,
  parameter int SIDE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [N-1:0]             in_bits,
  input  logic [SIDE_W-1:0]        in_side,
  output logic                     out_valid,
  output logic [$clog2(N+1)-1:0]   out_count,
  output logic [SIDE_W-1:0]        out_side
);

  localparam int LEVELS = $clog2(N);
  localparam int PAD_N  = 1 << LEVELS;
  localparam int RW     = $clog2(N+1);

  logic [LEVELS:0]   vld_d;
  logic [LEVELS:0]   vld_q;
  logic [SIDE_W-1:0] side_q [0:LEVELS];

  always_comb begin
    vld_d = {vld_q[LEVELS-1:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      side_q[0] <= in_side;
    end
    for (int s = 1; s <= LEVELS; s++) begin
      if (vld_q[s-1]) begin
        side_q[s] <= side_q[s-1];
      end
    end
  end

  genvar l;
  for (l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = PAD_N >> l;
    logic [CNT*RW-1:0] sum_d;
    logic [CNT*RW-1:0] sum_q;
    logic              en;

    if (l == 0) begin : g_leaf
      assign en = in_valid;
      always_comb begin
        sum_d = '0;
        for (int i = 0; i < N; i++) begin
          sum_d[i*RW +: RW] = RW'(in_bits[i]);
        end
      end
    end else begin : g_add
      assign en = vld_q[l-1];
      always_comb begin
        for (int i = 0; i < CNT; i++) begin
          sum_d[i*RW +: RW] = g_lvl[l-1].sum_q[(2*i)*RW +: RW]
                            + g_lvl[l-1].sum_q[(2*i+1)*RW +: RW];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (en) begin
        sum_q <= sum_d;
      end
    end
  end

  assign out_valid = vld_q[LEVELS];
  assign out_count = g_lvl[LEVELS].sum_q[RW-1:0];
  assign out_side  = side_q[LEVELS];

endmodule

// File: rtl/rbc_classify.sv
// Exact two-threshold classification of a wire count, with a registered result.
module rbc_classify
  import rbc_pkg::*;
#(
  parameter int N        = 16,
  parameter int FRAC_W   = 8,
  parameter int CNT_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CNT_BITS-1:0] in_count,
  input  logic [FRAC_W-1:0]   in_delta,
  input  logic                in_expect,
  output logic                out_valid,
  output logic [1:0]          out_code,
  output logic                out_miss
);

  localparam int PW = CNT_BITS + FRAC_W + 1;

  logic [PW-1:0] scaled_r;
  logic [PW-1:0] lo_lim;
  logic [PW-1:0] hi_lim;
  logic          above_hi;
  logic          below_lo;
  cls_e          code_d;
  logic          miss_d;
  logic          valid_q;
  cls_e          code_q;
  logic          miss_q;

  always_comb begin
    scaled_r = PW'(in_count) << FRAC_W;
    lo_lim   = PW'(N) * PW'(in_delta);
    hi_lim   = (PW'(N) << FRAC_W) - lo_lim;
    above_hi = scaled_r > hi_lim;
    below_lo = scaled_r < lo_lim;
    if (above_hi && !below_lo) begin
      code_d = CLS_ONE;
    end else if (below_lo && !above_hi) begin
      code_d = CLS_ZERO;
    end else begin
      code_d = CLS_ERR;
    end
    miss_d = (code_d == CLS_ERR) || (code_d[0] != in_expect);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      code_q <= code_d;
      miss_q <= miss_d;
    end
  end

  assign out_valid = valid_q;
  assign out_code  = code_q;
  assign out_miss  = miss_q;

endmodule

// File: rtl/rbc_tally.sv
// Saturating result tallies with a shared synchronous clear.
module rbc_tally
  import rbc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear_i,
  input  logic [TALLY_NUM-1:0]         hit_i,
  output logic [TALLY_NUM*CNT_W-1:0]   cnt_o
);

  genvar k;
  for (k = 0; k < TALLY_NUM; k++) begin : g_cnt
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
      if (clear_i) begin
        cnt_d = '0;
      end else if (hit_i[k] && (cnt_q != '1)) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_o[k*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/rep_bundle_codec.sv
module rep_bundle_codec
  import rbc_pkg::*;
#(
  parameter int BUNDLE_N = 16,
  parameter int FRAC_W   = 8,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enc_bit_i,
  output logic [BUNDLE_N-1:0] enc_bundle_o,
  input  logic                dec_valid_i,
  input  logic [BUNDLE_N-1:0] dec_bundle_i,
  input  logic [FRAC_W-1:0]   dec_delta_i,
  input  logic                dec_expect_i,
  input  logic                cnt_clear_i,
  output logic                cls_valid_o,
  output logic [1:0]          cls_code_o,
  output logic                cls_mismatch_o,
  output logic [CNT_W-1:0]    cnt_zero_o,
  output logic [CNT_W-1:0]    cnt_one_o,
  output logic [CNT_W-1:0]    cnt_err_o,
  output logic [CNT_W-1:0]    cnt_miss_o
);

  localparam int RW     = $clog2(BUNDLE_N + 1);
  localparam int SIDE_W = FRAC_W + 1;

  logic [SIDE_W-1:0]          side_in;
  logic                       pc_valid;
  logic [RW-1:0]              pc_count;
  logic [SIDE_W-1:0]          pc_side;
  logic [TALLY_NUM-1:0]       hit;
  logic [TALLY_NUM*CNT_W-1:0] tally;

  assign enc_bundle_o = {BUNDLE_N{enc_bit_i}};

  assign side_in = {dec_expect_i, dec_delta_i};

  rbc_popcount #(
    .N      (BUNDLE_N),
    .SIDE_W (SIDE_W)
  ) u_pop (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_valid_i),
    .in_bits   (dec_bundle_i),
    .in_side   (side_in),
    .out_valid (pc_valid),
    .out_count (pc_count),
    .out_side  (pc_side)
  );

  rbc_classify #(
    .N        (BUNDLE_N),
    .FRAC_W   (FRAC_W),
    .CNT_BITS (RW)
  ) u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pc_valid),
    .in_count  (pc_count),
    .in_delta  (pc_side[FRAC_W-1:0]),
    .in_expect (pc_side[FRAC_W]),
    .out_valid (cls_valid_o),
    .out_code  (cls_code_o),
    .out_miss  (cls_mismatch_o)
  );

  always_comb begin
    hit             = '0;
    hit[TALLY_ZERO] = cls_valid_o && (cls_code_o == CLS_ZERO);
    hit[TALLY_ONE]  = cls_valid_o && (cls_code_o == CLS_ONE);
    hit[TALLY_ERR]  = cls_valid_o && (cls_code_o == CLS_ERR);
    hit[TALLY_MISS] = cls_valid_o && cls_mismatch_o;
  end

  rbc_tally #(
    .CNT_W (CNT_W)
  ) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cnt_clear_i),
    .hit_i   (hit),
    .cnt_o   (tally)
  );

  assign cnt_zero_o = tally[TALLY_ZERO*CNT_W +: CNT_W];
  assign cnt_one_o  = tally[TALLY_ONE*CNT_W  +: CNT_W];
  assign cnt_err_o  = tally[TALLY_ERR*CNT_W  +: CNT_W];
  assign cnt_miss_o = tally[TALLY_MISS*CNT_W +: CNT_W];

endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
  parameter int BUNDLE_N = 16,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [BUNDLE_N-1:0] enc_bundle_o,
  input logic                dec_valid_i,
  input logic                cnt_clear_i,
  input logic                cls_valid_o,
  input logic [1:0]          cls_code_o,
  input logic                cls_mismatch_o,
  input logic [CNT_W-1:0]    cnt_zero_o,
  input logic [CNT_W-1:0]    cnt_one_o,
  input logic [CNT_W-1:0]    cnt_err_o,
  input logic [CNT_W-1:0]    cnt_miss_o
);

  localparam int LAT = $clog2(BUNDLE_N) + 1;

  logic [LAT:0] vld_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sh <= '0;
    end else begin
      vld_sh <= {vld_sh[LAT-1:0], dec_valid_i};
    end
  end

  AST_ENC_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_bundle_o == '0) || (enc_bundle_o == '1)); // R1

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid_o |-> (cls_code_o != 2'b11)); // R4

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid_o == vld_sh[LAT]); // R6

  AST_MISS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid_o && cls_code_o == 2'b10) |-> cls_mismatch_o); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear_i |=> (cnt_zero_o >= $past(cnt_zero_o)) && (cnt_one_o >= $past(cnt_one_o))
                  && (cnt_err_o >= $past(cnt_err_o)) && (cnt_miss_o >= $past(cnt_miss_o))); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear_i |=> (cnt_zero_o - $past(cnt_zero_o) <= 1) && (cnt_one_o - $past(cnt_one_o) <= 1)
                  && (cnt_err_o - $past(cnt_err_o) <= 1) && (cnt_miss_o - $past(cnt_miss_o) <= 1)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear_i |=> (cnt_zero_o == '0) && (cnt_one_o == '0)
                 && (cnt_err_o == '0) && (cnt_miss_o == '0)); // R9

endmodule

bind rep_bundle_codec rbc_checker #(
  .BUNDLE_N (BUNDLE_N),
  .CNT_W    (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enc_bundle_o   (enc_bundle_o),
  .dec_valid_i    (dec_valid_i),
  .cnt_clear_i    (cnt_clear_i),
  .cls_valid_o    (cls_valid_o),
  .cls_code_o     (cls_code_o),
  .cls_mismatch_o (cls_mismatch_o),
  .cnt_zero_o     (cnt_zero_o),
  .cnt_one_o      (cnt_one_o),
  .cnt_err_o      (cnt_err_o),
  .cnt_miss_o     (cnt_miss_o)
);

// File: tb/sim_rep_bundle_codec.sv
`timescale 1ns/1ps
module sim_rep_bundle_codec;

  localparam int N   = 16;
  localparam int FW  = 8;
  localparam int CW  = 4;
  localparam int LAT = $clog2(N) + 1;
  localparam int MAXC = (1 << CW) - 1;

  // {bundle, delta, expect, expected code}
  localparam logic [26:0] VEC [16] = '{
    {16'h0000, 8'd64,  1'b0, 2'b00},
    {16'hFFFF, 8'd64,  1'b1, 2'b01},
    {16'h0007, 8'd64,  1'b0, 2'b00},
    {16'h000F, 8'd64,  1'b0, 2'b10},
    {16'h0FFF, 8'd64,  1'b1, 2'b10},
    {16'h1FFF, 8'd64,  1'b1, 2'b01},
    {16'hFFFF, 8'd64,  1'b0, 2'b01},
    {16'h0001, 8'd1,   1'b0, 2'b10},
    {16'h0000, 8'd1,   1'b0, 2'b00},
    {16'hFFFF, 8'd1,   1'b1, 2'b01},
    {16'h7FFF, 8'd1,   1'b1, 2'b10},
    {16'h00FF, 8'd127, 1'b0, 2'b10},
    {16'h01FF, 8'd127, 1'b1, 2'b01},
    {16'h007F, 8'd127, 1'b1, 2'b00},
    {16'h0003, 8'd32,  1'b0, 2'b10},
    {16'h7FFF, 8'd32,  1'b1, 2'b01}
  };

  logic          clk;
  logic          rst_n;
  logic          enc_bit_i;
  logic [N-1:0]  enc_bundle_o;
  logic          dec_valid_i;
  logic [N-1:0]  dec_bundle_i;
  logic [FW-1:0] dec_delta_i;
  logic          dec_expect_i;
  logic          cnt_clear_i;
  logic          cls_valid_o;
  logic [1:0]    cls_code_o;
  logic          cls_mismatch_o;
  logic [CW-1:0] cnt_zero_o, cnt_one_o, cnt_err_o, cnt_miss_o;

  int checks = 0;
  int errors = 0;
  int tz = 0, to = 0, te = 0, tm = 0;

  rep_bundle_codec #(.BUNDLE_N(N), .FRAC_W(FW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_bit_i(enc_bit_i), .enc_bundle_o(enc_bundle_o),
    .dec_valid_i(dec_valid_i), .dec_bundle_i(dec_bundle_i), .dec_delta_i(dec_delta_i),
    .dec_expect_i(dec_expect_i), .cnt_clear_i(cnt_clear_i), .cls_valid_o(cls_valid_o),
    .cls_code_o(cls_code_o), .cls_mismatch_o(cls_mismatch_o), .cnt_zero_o(cnt_zero_o),
    .cnt_one_o(cnt_one_o), .cnt_err_o(cnt_err_o), .cnt_miss_o(cnt_miss_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic tally(input logic [1:0] c, input logic m);
    if (c == 2'b00) tz = sat_inc(tz);
    if (c == 2'b01) to = sat_inc(to);
    if (c == 2'b10) te = sat_inc(te);
    if (m) tm = sat_inc(tm);
  endtask

  task automatic check_tallies(input string req);
    check(req, cnt_zero_o, tz);
    check(req, cnt_one_o,  to);
    check(req, cnt_err_o,  te);
    check(req, cnt_miss_o, tm);
  endtask

  task automatic send(input logic [N-1:0] b, input logic [FW-1:0] d, input logic e,
                      input logic [1:0] c, input logic clr_hit, input logic alt_side);
    logic m;
    string creq;
    m = (c == 2'b10) || (c[0] != e);
    creq = (c == 2'b01) ? "R2" : (c == 2'b00) ? "R3" : "R4";
    if (alt_side) creq = "R5";
    @(negedge clk);
    dec_valid_i = 1'b1; dec_bundle_i = b; dec_delta_i = d; dec_expect_i = e;
    @(posedge clk);
    @(negedge clk);
    dec_valid_i = 1'b0;
    if (alt_side) begin
      dec_delta_i = 8'd127; dec_expect_i = ~e;
    end
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("R6 early", cls_valid_o, 0);
    @(posedge clk);
    @(negedge clk);
    check("R6 valid", cls_valid_o, 1);
    check(creq, cls_code_o, c);
    check("R7", cls_mismatch_o, m);
    if (clr_hit) begin
      cnt_clear_i = 1'b1;
      tz = 0; to = 0; te = 0; tm = 0;
    end else begin
      tally(c, m);
    end
    @(posedge clk);
    @(negedge clk);
    cnt_clear_i = 1'b0;
  endtask

  task automatic stream_ones(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_valid_i = 1'b1; dec_bundle_i = '1; dec_delta_i = 8'd64; dec_expect_i = 1'b1;
      tally(2'b01, 1'b0);
    end
    @(negedge clk);
    dec_valid_i = 1'b0;
    repeat (LAT + 3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enc_bit_i = 1'b0; dec_valid_i = 1'b0; dec_bundle_i = '0;
    dec_delta_i = 8'd64; dec_expect_i = 1'b0; cnt_clear_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 valid in reset", cls_valid_o, 0);
    check_tallies("R10 tallies in reset");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 valid after reset", cls_valid_o, 0);
    check_tallies("R10 tallies after reset");

    // R1 encoder
    enc_bit_i = 1'b1; #1;
    check("R1 ones", (enc_bundle_o == '1) ? 1 : 0, 1);
    enc_bit_i = 1'b0; #1;
    check("R1 zeros", (enc_bundle_o == '0) ? 1 : 0, 1);

    // Table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < 16; i++) begin
      send(VEC[i][26:11], VEC[i][10:3], VEC[i][2], VEC[i][1:0], 1'b0, 1'b0);
    end
    check_tallies("R8 table totals");

    // R5: delta and expect changed right after capture
    send(16'h0001, 8'd1, 1'b0, 2'b10, 1'b0, 1'b1);
    check_tallies("R5 tallies");

    // R9: clear in the same cycle as a counted result
    send(16'h000F, 8'd64, 1'b1, 2'b10, 1'b1, 1'b0);
    check_tallies("R9 clear beats increment");

    // R8: back-to-back results, then saturation
    stream_ones(10);
    check("R8 one per cycle", cnt_one_o, 10);
    check("R6 idle after burst", cls_valid_o, 0);
    stream_ones(8);
    check("R8 saturate", cnt_one_o, MAXC);
    check_tallies("R8 after saturation");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule